// File: doc/BRIEF.md
# Two-Level ALU Operation Decoder and Arithmetic-Logic Unit

This block turns a coarse operation class and an instruction's 6-bit function field into a 4-bit ALU operation select. It then performs the selected operation on two 32-bit operands. The main controller supplies a 2-bit class. One class forces addition, for load and store address generation. Another forces subtraction, for branch-on-equal comparison. A third defers to the function field of a register-type instruction. The ALU performs bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. Alongside the result it raises a zero flag, which the branch logic uses as its equality test.

The decoded select, the result and the zero flag are registered in a single output stage. A set of inputs applied before a rising clock edge therefore appears on the outputs just after that edge. Function codes that are not listed, and the unused fourth class, both fall back to addition, so the output is never undefined.

Top module: `alu_two_level`

## Requirements
- R1: Class 2'b00 selects addition (select 4'b0010) whatever the function field holds.
- R2: Class 2'b01 selects subtraction (select 4'b0110) whatever the function field holds.
- R3: Under class 2'b10 the function field chooses the operation: 6'h20 add (4'b0010), 6'h22 subtract (4'b0110), 6'h24 AND (4'b0000), 6'h25 OR (4'b0001), 6'h2A set-on-less-than (4'b0111).
- R4: Under class 2'b10, every function code not listed in R3 selects addition (4'b0010).
- R5: Class 2'b11 selects addition (4'b0010).
- R6: Addition and subtraction wrap modulo 2^32, and no carry or overflow is reported.
- R7: Set-on-less-than compares the operands as signed two's-complement numbers. It returns 1 in bit 0 when A < B and 0 otherwise, and all upper bits are zero.
- R8: The zero flag is 1 exactly when all 32 result bits are 0. Under class 2'b01 it is therefore 1 exactly when A equals B.
- R9: Outputs change one clock after the inputs are sampled. While reset is active, result is 0, zero is 1 and the select is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | output | 4 | Registered decoded operation select |
| result | output | 32 | Registered ALU result |
| zero | output | 1 | Registered all-zero flag of the result |

## Verification
On every cycle, the assertions check the class-to-select mapping for the forced classes, for the subtract function code and for the unlisted function codes. They also check the link between the zero flag and the result, the equality meaning of zero under the subtract class, the address sum, and that the upper result bits stay clear under set-on-less-than. Only the bench's scenarios can show the following: the full function-field table, the signed ordering of set-on-less-than at the sign boundary, wrap-around at the extremes of the operand range, and the reset values.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

    localparam int unsigned SEL_W   = 4;
    localparam int unsigned FUNCT_W = 6;
    localparam int unsigned CLASS_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111
    } op_sel_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM   = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FIELD = 2'b10,
        CLS_SPARE = 2'b11
    } op_class_e;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_ctl_pkg::*;
(
    input  logic [CLASS_W-1:0] cls_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output op_sel_e            sel_o
);

    op_sel_e field_sel;

    // second-level decode of the function field
    always_comb begin
        unique case (funct_i)
            FN_ADD:  field_sel = SEL_ADD;
            FN_SUB:  field_sel = SEL_SUB;
            FN_AND:  field_sel = SEL_AND;
            FN_OR:   field_sel = SEL_OR;
            FN_SLT:  field_sel = SEL_SLT;
            default: field_sel = SEL_ADD;
        endcase
    end

    // first-level decode of the class
    always_comb begin
        unique case (op_class_e'(cls_i))
            CLS_MEM:   sel_o = SEL_ADD;
            CLS_CMP:   sel_o = SEL_SUB;
            CLS_FIELD: sel_o = field_sel;
            default:   sel_o = SEL_ADD;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_ctl_pkg::*;
#(
    parameter int unsigned WIDTH        = 32,
    parameter bit          SHARED_ADDER = 1'b1
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  op_sel_e          sel_i,
    output logic [WIDTH-1:0] res_o,
    output logic             zero_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] diff_w;
    logic             less_w;

    generate
        if (SHARED_ADDER) begin : g_shared
            // one adder; B is inverted with carry-in for subtract-type selects
            logic             sub_mode;
            logic [WIDTH-1:0] b_eff;
            logic [WIDTH-1:0] adder_out;
            assign sub_mode  = (sel_i == SEL_SUB) || (sel_i == SEL_SLT);
            assign b_eff     = sub_mode ? ~b_i : b_i;
            assign adder_out = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_mode};
            assign sum_w     = adder_out;
            assign diff_w    = adder_out;
        end else begin : g_split
            assign sum_w  = a_i + b_i;
            assign diff_w = a_i - b_i;
        end
    endgenerate

    // signed less-than: sign of difference, corrected when operand signs differ
    assign less_w = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : diff_w[MSB];

    always_comb begin
        unique case (sel_i)
            SEL_AND: res_o = a_i & b_i;
            SEL_OR:  res_o = a_i | b_i;
            SEL_SUB: res_o = diff_w;
            SEL_SLT: res_o = {{(WIDTH-1){1'b0}}, less_w};
            default: res_o = sum_w;
        endcase
    end

    assign zero_o = ~|res_o;

endmodule

// File: rtl/alu_two_level.sv
module alu_two_level
    import alu_ctl_pkg::*;
#(
    parameter int unsigned WIDTH        = 32,
    parameter bit          SHARED_ADDER = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         op_class,
    input  logic [5:0]         funct,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    output logic [3:0]         op_sel,
    output logic [WIDTH-1:0]   result,
    output logic               zero
);

    typedef struct packed {
        op_sel_e          sel;
        logic [WIDTH-1:0] res;
        logic             zf;
    } stage_t;

    op_sel_e          dec_sel;
    logic [WIDTH-1:0] core_res;
    logic             core_zero;
    stage_t           st_d;
    stage_t           st_q;

    alu_op_decoder dec_i (
        .cls_i   (op_class),
        .funct_i (funct),
        .sel_o   (dec_sel)
    );

    alu_core #(
        .WIDTH        (WIDTH),
        .SHARED_ADDER (SHARED_ADDER)
    ) core_i (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .sel_i  (dec_sel),
        .res_o  (core_res),
        .zero_o (core_zero)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sel = dec_sel;
        st_d.res = core_res;
        st_d.zf  = core_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= SEL_AND;
            st_q.res <= '0;
            st_q.zf  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_sel = st_q.sel;
    assign result = st_q.res;
    assign zero   = st_q.zf;

endmodule

// File: rtl/alu_two_level_chk.sv
module alu_two_level_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       op_class,
    input logic [5:0]       funct,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] result,
    input logic             zero
);

    // R1
    mem_class_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b00 |=> op_sel == 4'b0010);

    // R1
    mem_class_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b00 |=> result == $past(opnd_a) + $past(opnd_b));

    // R2
    cmp_class_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b01 |=> op_sel == 4'b0110);

    // R3
    field_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && funct == 6'h22) |=> op_sel == 4'b0110);

    // R4
    field_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && funct != 6'h20 && funct != 6'h22 && funct != 6'h24
         && funct != 6'h25 && funct != 6'h2A) |=> op_sel == 4'b0010);

    // R5
    spare_class_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b11 |=> op_sel == 4'b0010);

    // R7
    slt_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'b0111 |-> result[WIDTH-1:1] == '0);

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));

    // R8
    cmp_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class == 2'b01 |=> zero == ($past(opnd_a) == $past(opnd_b)));

endmodule

bind alu_two_level alu_two_level_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_class (op_class),
    .funct    (funct),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .op_sel   (op_sel),
    .result   (result),
    .zero     (zero)
);

// File: tb/alu_two_level_tb_top.sv
`timescale 1ns/1ps
module alu_two_level_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic [5:0]  funct = 6'h00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel;
    logic [31:0] result;
    logic        zero;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [3:0]  sel;
        logic [31:0] res;
        logic        zf;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    alu_two_level dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_class (op_class),
        .funct    (funct),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .op_sel   (op_sel),
        .result   (result),
        .zero     (zero)
    );

    function automatic exp_t model(logic [1:0] c, logic [5:0] f,
                                   logic [31:0] a, logic [31:0] b, string tag);
        exp_t e;
        case (c)
            2'b00: e.sel = 4'b0010;
            2'b01: e.sel = 4'b0110;
            2'b10: case (f)
                6'h20: e.sel = 4'b0010;
                6'h22: e.sel = 4'b0110;
                6'h24: e.sel = 4'b0000;
                6'h25: e.sel = 4'b0001;
                6'h2A: e.sel = 4'b0111;
                default: e.sel = 4'b0010;
            endcase
            default: e.sel = 4'b0010;
        endcase
        case (e.sel)
            4'b0000: e.res = a & b;
            4'b0001: e.res = a | b;
            4'b0110: e.res = a - b;
            4'b0111: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: e.res = a + b;
        endcase
        e.zf  = (e.res == 32'd0);
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(logic [1:0] c, logic [5:0] f,
                         logic [31:0] a, logic [31:0] b, string tag);
        @(negedge clk);
        op_class = c;
        funct    = f;
        opnd_a   = a;
        opnd_b   = b;
        exp_q.push_back(model(c, f, a, b, tag));
    endtask

    task automatic compare(exp_t e);
        n_vec++;
        if (op_sel !== e.sel || result !== e.res || zero !== e.zf) begin
            n_bad++;
            $display("FAIL %s: sel=%b res=%h zero=%b expected sel=%b res=%h zero=%b",
                     e.tag, op_sel, result, zero, e.sel, e.res, e.zf);
        end
    endtask

    // monitor: the item pushed before this edge is what the edge registers
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() != 0) begin
                exp_t cur;
                cur = exp_q.pop_front();
                #1;
                compare(cur);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        opnd_a   = 32'hDEAD_BEEF;
        opnd_b   = 32'h1234_5678;
        op_class = 2'b10;
        funct    = 6'h25;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        begin
            exp_t r;
            r.sel = 4'b0000; r.res = 32'd0; r.zf = 1'b1; r.tag = "R9 reset";
            compare(r);
        end
        rst_n = 1'b1;

        // R1: funct ignored under class 00
        drive(2'b00, 6'h22, 32'd100, 32'd28, "R1 add");
        drive(2'b00, 6'h24, 32'hFFFF_FFFC, 32'd4, "R1 add to zero");
        // R2
        drive(2'b01, 6'h20, 32'd77, 32'd77, "R2 sub equal");
        drive(2'b01, 6'h25, 32'd5, 32'd9, "R2 sub differ");
        // R3
        drive(2'b10, 6'h20, 32'h7000_0001, 32'h0FFF_FFFF, "R3 add");
        drive(2'b10, 6'h22, 32'd10, 32'd3, "R3 sub");
        drive(2'b10, 6'h24, 32'hF0F0_F0F0, 32'hFF00_FF00, "R3 and");
        drive(2'b10, 6'h25, 32'h0000_00F0, 32'h0F00_000F, "R3 or");
        drive(2'b10, 6'h2A, 32'd3, 32'd8, "R3 slt");
        // R4
        drive(2'b10, 6'h21, 32'd6, 32'd7, "R4 unlisted 21");
        drive(2'b10, 6'h00, 32'd1, 32'd2, "R4 unlisted 00");
        drive(2'b10, 6'h3F, 32'hFFFF_FFFF, 32'd1, "R4 unlisted 3F");
        // R5
        drive(2'b11, 6'h22, 32'd40, 32'd2, "R5 spare class");
        // R6 wrap
        drive(2'b10, 6'h20, 32'hFFFF_FFFF, 32'd2, "R6 add wrap");
        drive(2'b01, 6'h00, 32'd0, 32'd1, "R6 sub wrap");
        drive(2'b10, 6'h22, 32'h8000_0000, 32'd1, "R6 sub min");
        // R7 signed ordering
        drive(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'd1, "R7 neg lt pos");
        drive(2'b10, 6'h2A, 32'd1, 32'hFFFF_FFFF, "R7 pos not lt neg");
        drive(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, "R7 min lt max");
        drive(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, "R7 max not lt min");
        drive(2'b10, 6'h2A, 32'd9, 32'd9, "R7 equal");
        // R8 zero via logic ops
        drive(2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555, "R8 and zero");
        drive(2'b10, 6'h25, 32'd0, 32'd0, "R8 or zero");
        // back-to-back mixed traffic
        for (int i = 0; i < 200; i++) begin
            logic [1:0]  c;
            logic [5:0]  f;
            logic [31:0] a;
            logic [31:0] b;
            c = 2'($urandom);
            case ($urandom % 6)
                0: f = 6'h20;
                1: f = 6'h22;
                2: f = 6'h24;
                3: f = 6'h25;
                4: f = 6'h2A;
                default: f = 6'($urandom);
            endcase
            a = $urandom;
            b = ($urandom % 4 == 0) ? a : $urandom;
            drive(c, f, a, b, "R9 mixed stream");
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule